// File: doc/BRIEF.md
# Chainable Active-Low Priority Encoder

This block turns a bank of active-low request lines into the binary index of the most important pending request. The index is also active-low. The block is built from identical eight-lane stages. Each stage has an active-low enable input and an active-low enable output. The enable output of one stage feeds the enable input of the next, less significant stage, so a pending request in a higher stage silences every stage below it.

The top level chains `STAGES` such stages, two by default, into one wider encoder. The external enable goes to the most significant stage. The lower code bits are the bitwise AND of all stage codes, which works because a silenced stage drives all ones. The upper code bits encode which stage reports a request; with two stages this bit is the upper stage's group-select output.

The block is purely combinational. Inside a stage, each lane first forms a one-hot "winner" term: the lane is requesting and no higher lane is. The code is built from these terms, not from the raw requests.

Top module: `prienc_chain`

## Requirements
- R1: With `ei_n` low and at least one `req_n` bit low, `code_n` equals the bitwise inverse of the highest index whose `req_n` bit is low (index 15 has the highest priority, index 0 the lowest).
- R2: Lower requests never add bits to the code: with only lines 2 and 4 requesting, `code_n` reads the inverse of 4 (4'b1011), not the inverse of 6.
- R3: `gs_n` is low exactly when `ei_n` is low and at least one request is active.
- R4: `eo_n` is low exactly when `ei_n` is low and no request is active.
- R5: With `ei_n` high, `code_n`, `gs_n` and `eo_n` are all high, whatever the requests.
- R6: With `ei_n` low and no request active, `code_n` reads all ones.
- R7: Any request on lines 8..15 overrides all requests on lines 0..7. Bit 3 of `code_n` is low exactly when the upper stage reports a request, and at most one stage reports a request at a time.
- R8: `gs_n` and `eo_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | STAGES*LANES (16) | Active-low request lines; a higher index has higher priority |
| ei_n | input | 1 | Active-low enable into the most significant stage |
| code_n | output | log2(STAGES*LANES) (4) | Active-low index of the winning request |
| gs_n | output | 1 | Active-low: some request is active and the block is enabled |
| eo_n | output | 1 | Active-low: the block is enabled and idle; feeds a further, lower chain |

## Verification
All 65,536 request patterns are applied twice, once with the enable active and once with it inactive. In the inactive half, any output that leaks the request value shows up; in the active half, each pattern's highest set index is compared with the code. The patterns include every mix of lines in the upper and lower banks, so a broken enable chain, an AND merge that uses the wrong stage, or a code built as an OR of the raw requests each gives a wrong index for some pattern. Directed checks cover the idle pattern, lines 2 and 4 together, and an upper request against a full lower bank.

// File: rtl/pe_pkg.sv
package pe_pkg;
  parameter int unsigned PE_LANES  = 8;
  parameter int unsigned PE_STAGES = 2;
endpackage

// File: rtl/pe_pick.sv
module pe_pick #(
  parameter int unsigned LANES = pe_pkg::PE_LANES
) (
  input  logic             en,
  input  logic [LANES-1:0] req,
  output logic [LANES-1:0] hot
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == LANES - 1) begin : g_top
      assign hot[i] = en & req[i];
    end else begin : g_rest
      assign hot[i] = en & req[i] & ~(|req[LANES-1:i+1]);
    end
  end

  always_comb begin
    AST_WINNER_ONEHOT: assert ($onehot0(hot)); // R1
  end
endmodule

// File: rtl/pe_pack.sv
module pe_pack #(
  parameter int unsigned LANES = pe_pkg::PE_LANES,
  localparam int unsigned CW = $clog2(LANES)
) (
  input  logic [LANES-1:0] hot,
  output logic [CW-1:0]    code,
  output logic             any
);
  always_comb begin
    code = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hot[i]) code = code | CW'(i);
    end
    any = |hot;
  end
endmodule

// File: rtl/pe_stage.sv
module pe_stage #(
  parameter int unsigned LANES = pe_pkg::PE_LANES,
  localparam int unsigned CW = $clog2(LANES)
) (
  input  logic [LANES-1:0] req_n,
  input  logic             ei_n,
  output logic [CW-1:0]    code_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic             en;
  logic [LANES-1:0] req;
  logic [LANES-1:0] hot;
  logic [CW-1:0]    code;
  logic             any;

  assign en  = ~ei_n;
  assign req = ~req_n;

  pe_pick #(.LANES(LANES)) u_pick (.en(en), .req(req), .hot(hot));
  pe_pack #(.LANES(LANES)) u_pack (.hot(hot), .code(code), .any(any));

  assign code_n = ~code;
  assign gs_n   = ~any;
  assign eo_n   = ~(en & ~(|req));

  always_comb begin
    AST_GS_EO_EXCL: assert (!(!gs_n && !eo_n)); // R8
    AST_DISABLED_QUIET: assert (!ei_n || (gs_n && eo_n && &code_n)); // R5
    AST_IDLE_CODE_HIGH: assert (!(!eo_n) || &code_n); // R6
  end
endmodule

// File: rtl/prienc_chain.sv
module prienc_chain #(
  parameter int unsigned LANES  = pe_pkg::PE_LANES,
  parameter int unsigned STAGES = pe_pkg::PE_STAGES,
  localparam int unsigned TOTAL = LANES * STAGES,
  localparam int unsigned LCW   = $clog2(LANES),
  localparam int unsigned SCW   = $clog2(STAGES),
  localparam int unsigned CW    = LCW + SCW
) (
  input  logic [TOTAL-1:0] req_n,
  input  logic             ei_n,
  output logic [CW-1:0]    code_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic [LCW-1:0]  st_code_n [STAGES];
  logic [STAGES-1:0] st_gs_n;
  logic [STAGES-1:0] st_eo_n;
  logic [STAGES:0]   chain_n;

  assign chain_n[STAGES] = ei_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    pe_stage #(.LANES(LANES)) u_stage (
      .req_n (req_n[s*LANES +: LANES]),
      .ei_n  (chain_n[s+1]),
      .code_n(st_code_n[s]),
      .gs_n  (st_gs_n[s]),
      .eo_n  (st_eo_n[s])
    );
    assign chain_n[s] = st_eo_n[s];
  end

  logic [LCW-1:0] low_n;
  logic [SCW-1:0] sel;

  always_comb begin
    low_n = '1;
    sel   = '0;
    for (int s = 0; s < STAGES; s++) begin
      low_n = low_n & st_code_n[s];
      if (!st_gs_n[s]) sel = sel | SCW'(s);
    end
  end

  assign code_n = {~sel, low_n};
  assign gs_n   = &st_gs_n;
  assign eo_n   = st_eo_n[0];

  always_comb begin
    AST_ONE_STAGE_ACTIVE: assert ($countones(~st_gs_n) <= 1); // R7
    AST_TOP_GS_EO_EXCL: assert (!(!gs_n && !eo_n)); // R8
  end
endmodule

// File: tb/sim_prienc_chain.sv
module sim_prienc_chain;
  localparam int unsigned N  = 16;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_n = '1;
  logic          ei_n = 1'b1;
  logic [CW-1:0] code_n;
  logic          gs_n;
  logic          eo_n;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prienc_chain u0 (.req_n(req_n), .ei_n(ei_n), .code_n(code_n), .gs_n(gs_n), .eo_n(eo_n));

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b (req_n=%h ei_n=%b)", tag, act, exp, req_n, ei_n);
    end
  endtask

  function automatic logic [5:0] model(input logic [N-1:0] r_n, input logic e_n);
    logic [N-1:0] r;
    int top;
    r = ~r_n;
    top = -1;
    for (int i = 0; i < N; i++) if (r[i]) top = i;
    if (e_n) return 6'b111111;
    if (top < 0) return {4'b1111, 1'b1, 1'b0};
    return {~4'(top), 1'b0, 1'b1};
  endfunction

  task automatic apply(input logic [N-1:0] r_n, input logic e_n, input string tag);
    @(posedge clk);
    req_n = r_n;
    ei_n  = e_n;
    @(negedge clk);
    check(tag, {code_n, gs_n, eo_n}, model(r_n, e_n));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 reset-quiet", {code_n, gs_n, eo_n}, 6'b111111);
    rst_n = 1'b1;

    // R6 / R4: enabled, no requests
    apply('1, 1'b0, "R6 idle");
    // R2: lines 2 and 4 give index 4
    apply(~16'h0014, 1'b0, "R2 two-and-four");
    @(negedge clk);
    check("R2 code", {2'b00, code_n}, {2'b00, 4'b1011});
    // R7: upper line beats a full lower bank
    apply(~16'h01FF, 1'b0, "R7 upper-wins");
    check("R7 bit3", {5'b0, code_n[3]}, 6'b0);
    apply(~16'h00FF, 1'b0, "R7 lower-only");
    check("R7 bit3-high", {5'b0, code_n[3]}, 6'b1);

    // Exhaustive: R1, R3, R4, R5, R8 over every pattern
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 65536; p++) begin
        logic [N-1:0] rn;
        rn = ~16'(p);
        if (e == 1) apply(rn, 1'b1, "R5 disabled");
        else if (p == 0) apply(rn, 1'b0, "R4 idle-eo");
        else apply(rn, 1'b0, "R1 R3 priority");
        if (!gs_n && !eo_n) check("R8 excl", {gs_n, eo_n, 4'b0}, 6'b010000);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule